// File: doc/BRIEF.md
# Cell-Based Multicast Demultiplexing Router

This block takes fixed-length cells from a single input port and places each whole cell into one or more of four output queues. Each queue holds 64 words of 18 bits, or 128 bytes of 9 bits. Each cell is a fixed count of such words, set with `cfg_cell_words` (8 to 64 words, so 16 to 128 bytes). All queues must be empty whenever that setting changes. The input carries either one 9-bit byte per beat (narrow) or two bytes per beat (wide). The lower byte of a wide beat comes out first.

There are four routing modes, selected by `cfg_mode`:
- **0, side-band unicast:** the queue index is `in_addr[1:0]`.
- **1, side-band multicast:** `in_addr[3:0]` is a queue bitmask.
- **2, in-band unicast:** the first beat of the transfer is a routing word. Its `in_data[1:0]` gives the queue index, and the result is then gated by the bitmask `in_addr[3:0]`.
- **3, in-band multicast:** the routing word's `in_data[3:0]` is a bitmask, ANDed with `in_addr[3:0]`.

In every mode, an address with `in_addr[4]` set routes the cell nowhere. The routing word is removed from the cell. Each output port gives one 9-bit byte per read, or, in nibble mode, the low nibble and then the high nibble of each byte.

The ingress control has two states:
- `W_IDLE`: it waits for a beat with start-of-cell. It goes to `W_BODY` on any start-of-cell beat.
- `W_BODY`: it counts data beats. It returns to `W_IDLE` on the last beat of the cell.

Each queue has a read phase with two states:
- `RD_LO` moves to `RD_HI` on a read in nibble mode.
- `RD_HI` moves back to `RD_LO` on the next read.

Top module: `cell_mcast_router`

## Requirements
- R1: After reset every `out_clav` is 0, `err_flag` is 0, and `in_clav` is 1 when no queue is occupied.
- R2: In side-band unicast, a cell goes only to queue `in_addr[1:0]` when `in_addr[4]` is 0. Its bytes come out in arrival order, with a wide beat giving bits [8:0] before bits [17:9].
- R3: In side-band multicast, a cell is copied to every queue whose bit is set in `in_addr[3:0]`, and to no queue when `in_addr[4]` is 1.
- R4: In in-band modes, the start-of-cell beat is a routing word that is never stored. The destination mask is the routing-word mask ANDed with `in_addr[3:0]`: for unicast the routing-word mask is one-hot of `in_data[1:0]`, and for multicast it is `in_data[3:0]`.
- R5: In narrow mode only `in_data[8:0]` is used per beat, two beats fill one queue word, and the byte order is kept.
- R6: `out_clav` rises on the cycle after the last beat of a cell is taken. It stays low while the cell is only partly written, and falls only after the last byte of the last stored cell is read.
- R7: `out_soc` is 1 exactly while the first byte (first nibble in nibble mode) of a cell is presented.
- R8: With `cfg_nib[q]` set, each byte is read as two beats: bits [3:0], then bits [7:4]. Output bits [8:4] are 0.
- R9: `in_clav` is 0 in `W_BODY`. In `W_IDLE` it is 0 if any possible destination lacks room for a full cell; in in-band modes every queue counts as a possible destination. A queue without room is left out of the write.
- R10: A write-enabled beat without start-of-cell in `W_IDLE` is discarded and sets `err_flag`, which stays set until reset.
- R11: A read enable on a queue with no complete cell changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Routing mode 0..3 |
| cfg_wide | input | 1 | 1: two bytes per input beat |
| cfg_cell_words | input | 7 | Cell length in 18-bit words (8..64) |
| cfg_nib | input | 4 | Per-queue nibble output mode |
| in_soc | input | 1 | Start of cell on the input |
| in_en_n | input | 1 | Active-low input beat enable |
| in_data | input | 18 | Input data |
| in_addr | input | 5 | Side-band address |
| in_clav | output | 1 | Input may start a cell |
| err_flag | output | 1 | Sticky framing error |
| out_en_n | input | 4 | Active-low per-queue read enable |
| out_soc | output | 4 | Per-queue start of cell |
| out_clav | output | 4 | Per-queue complete cell stored |
| out_data | output | 36 | Queue q byte in bits [9q+8:9q] |

## Verification
Directed cells exercise each routing mode on its own:
- A routing word whose mask is cancelled by the address shows that in-band selection uses both buses.
- A full queue paired with a multicast that names it shows the room exclusion.

Random rounds then mix mode, width, address, routing word, cell length and nibble setting, with up to three cells per round. The byte stream read back from each queue tells apart a wrong mask, a stored routing word, a swapped byte or nibble order, and a wrong cell length.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
    typedef enum logic [1:0] {
        RT_OB_UNI = 2'd0,
        RT_OB_MC  = 2'd1,
        RT_IB_UNI = 2'd2,
        RT_IB_MC  = 2'd3
    } route_mode_t;

    typedef enum logic { W_IDLE, W_BODY } wr_state_t;
    typedef enum logic { RD_LO, RD_HI } nib_state_t;
endpackage

// File: rtl/rtr_ingress.sv
module rtr_ingress
    import rtr_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  route_mode_t         cfg_mode,
    input  logic                cfg_wide,
    input  logic [CNT_W-1:0]    cfg_cell_words,
    input  logic                in_soc,
    input  logic                in_en_n,
    input  logic [2*BYTE_W-1:0] in_data,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [NQ-1:0]       q_room,
    output logic                in_clav,
    output logic [NQ-1:0]       wr_mask,
    output logic [2*BYTE_W-1:0] wr_data,
    output logic                wr_last,
    output logic                err_flag
);
    localparam int QSEL_W = $clog2(NQ);

    wr_state_t          state, nstate;
    logic [NQ-1:0]      mask_q;
    logic [CNT_W:0]     cnt_q;
    logic [BYTE_W-1:0]  hold_q;
    logic               err_q;

    logic               beat, inband, addr_ok, data_beat, pair_done;
    logic [CNT_W:0]     beats, idx;
    logic [NQ-1:0]      adr_uni, adr_mc, ob_mask, raw_mask, cur_mask;

    function automatic logic [NQ-1:0] sel1(input logic [QSEL_W-1:0] s);
        sel1 = '0;
        sel1[s] = 1'b1;
    endfunction

    assign beat    = ~in_en_n;
    assign inband  = (cfg_mode == RT_IB_UNI) || (cfg_mode == RT_IB_MC);
    assign addr_ok = (in_addr[ADDR_W-1:NQ] == '0);
    assign beats   = cfg_wide ? {1'b0, cfg_cell_words} : {cfg_cell_words, 1'b0};
    assign adr_uni = addr_ok ? sel1(in_addr[QSEL_W-1:0]) : '0;
    assign adr_mc  = addr_ok ? in_addr[NQ-1:0] : '0;
    assign ob_mask = (cfg_mode == RT_OB_MC) ? adr_mc : adr_uni;

    always_comb begin
        unique case (cfg_mode)
            RT_OB_UNI: raw_mask = adr_uni;
            RT_OB_MC:  raw_mask = adr_mc;
            RT_IB_UNI: raw_mask = sel1(in_data[QSEL_W-1:0]) & adr_mc;
            RT_IB_MC:  raw_mask = in_data[NQ-1:0] & adr_mc;
            default:   raw_mask = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            W_IDLE: if (beat && in_soc) nstate = W_BODY;
            W_BODY: if (data_beat && (idx == beats - 1'b1)) nstate = W_IDLE;
            default: nstate = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cur_mask  = (state == W_IDLE) ? (raw_mask & q_room) : mask_q;
        idx       = (state == W_IDLE) ? '0 : cnt_q;
        data_beat = beat && ((state == W_BODY) || (in_soc && !inband));
        pair_done = cfg_wide || idx[0];
        wr_mask   = (data_beat && pair_done) ? cur_mask : '0;
        wr_data   = cfg_wide ? in_data : {in_data[BYTE_W-1:0], hold_q};
        wr_last   = data_beat && (idx == beats - 1'b1);
        if (state == W_IDLE)
            in_clav = inband ? (&q_room) : ((ob_mask & ~q_room) == '0);
        else
            in_clav = 1'b0;
        err_flag  = err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (state == W_IDLE && beat) begin
                if (in_soc) begin
                    mask_q <= raw_mask & q_room;
                    cnt_q  <= inband ? '0 : {{CNT_W{1'b0}}, 1'b1};
                end else begin
                    err_q  <= 1'b1;
                end
            end else if (state == W_BODY && beat) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (data_beat && !idx[0]) hold_q <= in_data[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/rtr_queue.sv
module rtr_queue
    import rtr_pkg::*;
#(
    parameter int BYTE_W  = 9,
    parameter int Q_WORDS = 64,
    parameter int PTR_W   = 6,
    parameter int CNT_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cfg_cell_words,
    input  logic                cfg_nib,
    input  logic                wr_en,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic                wr_last,
    input  logic                rd_en_n,
    output logic [CNT_W-1:0]    used_words,
    output logic                out_soc,
    output logic                out_clav,
    output logic [BYTE_W-1:0]   out_data
);
    logic [2*BYTE_W-1:0] mem [Q_WORDS];
    logic [PTR_W-1:0]    wptr;
    logic [PTR_W:0]      rptr;
    logic [CNT_W-1:0]    used, cells;
    logic [CNT_W:0]      cbyte, cell_bytes;
    nib_state_t          nst;

    logic                rd_fire, byte_adv, word_done, cell_done, cell_in;
    logic [2*BYTE_W-1:0] cur_word;
    logic [BYTE_W-1:0]   cur_byte;
    logic [3:0]          nib;

    assign cell_bytes = {cfg_cell_words, 1'b0};
    assign rd_fire    = ~rd_en_n && (cells != '0);
    assign byte_adv   = rd_fire && (!cfg_nib || nst == RD_HI);
    assign word_done  = byte_adv && rptr[0];
    assign cell_done  = byte_adv && (cbyte == cell_bytes - 1'b1);
    assign cell_in    = wr_en && wr_last;

    assign cur_word = mem[rptr[PTR_W:1]];
    assign cur_byte = rptr[0] ? cur_word[2*BYTE_W-1:BYTE_W] : cur_word[BYTE_W-1:0];
    assign nib      = (nst == RD_HI) ? cur_byte[7:4] : cur_byte[3:0];

    assign out_data   = cfg_nib ? {{(BYTE_W-4){1'b0}}, nib} : cur_byte;
    assign out_clav   = (cells != '0);
    assign out_soc    = out_clav && (cbyte == '0) && (nst == RD_LO);
    assign used_words = used;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            used  <= '0;
            cells <= '0;
            cbyte <= '0;
            nst   <= RD_LO;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (byte_adv) begin
                rptr  <= rptr + 1'b1;
                cbyte <= cell_done ? '0 : cbyte + 1'b1;
            end
            if (rd_fire && cfg_nib)
                nst <= (nst == RD_LO) ? RD_HI : RD_LO;
            unique case ({wr_en, word_done})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
            unique case ({cell_in, cell_done})
                2'b10:   cells <= cells + 1'b1;
                2'b01:   cells <= cells - 1'b1;
                default: cells <= cells;
            endcase
        end
    end
endmodule

// File: rtl/cell_mcast_router.sv
module cell_mcast_router
    import rtr_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int BYTE_W  = 9,
    parameter int Q_WORDS = 64,
    parameter int ADDR_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_wide,
    input  logic [6:0]           cfg_cell_words,
    input  logic [NQ-1:0]        cfg_nib,
    input  logic                 in_soc,
    input  logic                 in_en_n,
    input  logic [2*BYTE_W-1:0]  in_data,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 in_clav,
    output logic                 err_flag,
    input  logic [NQ-1:0]        out_en_n,
    output logic [NQ-1:0]        out_soc,
    output logic [NQ-1:0]        out_clav,
    output logic [NQ*BYTE_W-1:0] out_data
);
    localparam int PTR_W = $clog2(Q_WORDS);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W:0] Q_LIM = Q_WORDS[CNT_W:0];

    route_mode_t                 mode_e;
    logic [NQ-1:0]               wr_mask, q_room;
    logic [2*BYTE_W-1:0]         wr_data;
    logic                        wr_last;
    logic [NQ-1:0][CNT_W-1:0]    q_used;

    assign mode_e = route_mode_t'(cfg_mode);

    rtr_ingress #(.NQ(NQ), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_in (
        .clk(clk), .rst_n(rst_n), .cfg_mode(mode_e), .cfg_wide(cfg_wide),
        .cfg_cell_words(cfg_cell_words), .in_soc(in_soc), .in_en_n(in_en_n),
        .in_data(in_data), .in_addr(in_addr), .q_room(q_room), .in_clav(in_clav),
        .wr_mask(wr_mask), .wr_data(wr_data), .wr_last(wr_last), .err_flag(err_flag)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign q_room[q] = ({1'b0, q_used[q]} + {1'b0, cfg_cell_words}) <= Q_LIM;

        rtr_queue #(.BYTE_W(BYTE_W), .Q_WORDS(Q_WORDS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_q (
            .clk(clk), .rst_n(rst_n), .cfg_cell_words(cfg_cell_words),
            .cfg_nib(cfg_nib[q]), .wr_en(wr_mask[q]), .wr_data(wr_data),
            .wr_last(wr_last), .rd_en_n(out_en_n[q]), .used_words(q_used[q]),
            .out_soc(out_soc[q]), .out_clav(out_clav[q]),
            .out_data(out_data[q*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/rtr_chk.sv
module rtr_chk #(
    parameter int NQ      = 4,
    parameter int CNT_W   = 7,
    parameter int Q_WORDS = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_clav,
    input logic                     in_en_n,
    input logic                     in_soc,
    input logic                     err_flag,
    input logic [NQ-1:0]            out_en_n,
    input logic [NQ-1:0]            out_soc,
    input logic [NQ-1:0]            out_clav,
    input logic [NQ-1:0][CNT_W-1:0] q_used
);
    localparam logic [CNT_W-1:0] LIM = Q_WORDS[CNT_W-1:0];

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(!in_en_n && !in_soc));

    for (genvar q = 0; q < NQ; q++) begin : g_c
        // R9
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_used[q] <= LIM);

        // R6
        clav_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(out_clav[q]) |-> $past(!out_en_n[q]));

        // R7
        soc_clav_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_soc[q] |-> out_clav[q]);

        // R11
        idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_clav[q] && out_en_n[q] == 1'b0) |=> (q_used[q] >= $past(q_used[q])));
    end
endmodule

bind cell_mcast_router rtr_chk #(.NQ(NQ), .CNT_W(CNT_W), .Q_WORDS(Q_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_clav(in_clav), .in_en_n(in_en_n), .in_soc(in_soc),
    .err_flag(err_flag), .out_en_n(out_en_n), .out_soc(out_soc),
    .out_clav(out_clav), .q_used(q_used)
);

// File: tb/sim_cell_mcast_router.sv
module sim_cell_mcast_router;
    localparam int NQ = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic        cfg_wide;
    logic [6:0]  cfg_cell_words;
    logic [3:0]  cfg_nib;
    logic        in_soc, in_en_n;
    logic [17:0] in_data;
    logic [4:0]  in_addr;
    logic        in_clav, err_flag;
    logic [3:0]  out_en_n, out_soc, out_clav;
    logic [35:0] out_data;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [8:0] mq [NQ][$];
    int m_used [NQ];
    int m_cells[NQ];
    int cw;

    cell_mcast_router u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit room(input int q);
        return (m_used[q] + cw) <= 64;
    endfunction

    function automatic logic [3:0] all_room();
        logic [3:0] r;
        for (int q = 0; q < NQ; q++) r[q] = room(q);
        return r;
    endfunction

    function automatic logic [3:0] exp_raw(input int mode, input logic [4:0] a, input logic [17:0] h);
        logic [3:0] m;
        if (a[4]) return 4'b0;
        case (mode)
            0: m = 4'b1 << a[1:0];
            1: m = a[3:0];
            2: m = (4'b1 << h[1:0]) & a[3:0];
            default: m = h[3:0] & a[3:0];
        endcase
        return m;
    endfunction

    function automatic bit exp_clav(input int mode, input logic [4:0] a);
        logic [3:0] ob;
        if (mode >= 2) return &all_room();
        ob = exp_raw(mode, a, 18'd0);
        return (ob & ~all_room()) == 4'b0;
    endfunction

    task automatic send_cell(input int mode, input bit wide, input logic [4:0] a,
                             input logic [17:0] h);
        logic [3:0] m;
        logic [8:0] bytes[$];
        int nb;
        @(negedge clk);
        cfg_mode = 2'(mode);
        cfg_wide = wide;
        in_addr  = a;
        #1;
        chk(in_clav == exp_clav(mode, a), "R9 in_clav", int'(in_clav), int'(exp_clav(mode, a)));
        m  = exp_raw(mode, a, h) & all_room();
        nb = wide ? cw : 2 * cw;
        if (mode >= 2) begin
            in_en_n = 1'b0; in_soc = 1'b1; in_data = h;
            @(negedge clk);
        end
        for (int b = 0; b < nb; b++) begin
            in_en_n = 1'b0;
            in_soc  = (b == 0) && (mode < 2);
            in_data = 18'($urandom);
            bytes.push_back(in_data[8:0]);
            if (wide) bytes.push_back(in_data[17:9]);
            if (b == nb - 1)
                for (int q = 0; q < NQ; q++)
                    if (m[q] && m_cells[q] == 0)
                        chk(out_clav[q] == 1'b0, "R6 partial cell", int'(out_clav[q]), 0);
            if (b == 1)
                chk(in_clav == 1'b0, "R9 clav in body", int'(in_clav), 0);
            @(negedge clk);
        end
        in_en_n = 1'b1; in_soc = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (m[q]) begin
                foreach (bytes[i]) mq[q].push_back(bytes[i]);
                m_used[q] += cw;
                m_cells[q]++;
            end
            chk(out_clav[q] == (m_cells[q] > 0), "R2 R3 R4 R6 destination clav",
                int'(out_clav[q]), int'(m_cells[q] > 0));
        end
    endtask

    task automatic read_cell(input int q);
        logic [8:0] b, e;
        int np;
        np = cfg_nib[q] ? 2 : 1;
        for (int i = 0; i < 2 * cw; i++) begin
            b = mq[q].pop_front();
            for (int ph = 0; ph < np; ph++) begin
                e = cfg_nib[q] ? {5'b0, (ph == 1) ? b[7:4] : b[3:0]} : b;
                chk(out_data[q*9 +: 9] == e, cfg_nib[q] ? "R8 nibble data" : "R2 R5 byte data",
                    int'(out_data[q*9 +: 9]), int'(e));
                chk(out_soc[q] == (i == 0 && ph == 0), "R7 out_soc",
                    int'(out_soc[q]), int'(i == 0 && ph == 0));
                out_en_n[q] = 1'b0;
                @(negedge clk);
            end
        end
        out_en_n[q] = 1'b1;
        m_cells[q]--;
        m_used[q] -= cw;
        chk(out_clav[q] == (m_cells[q] > 0), "R6 clav after read",
            int'(out_clav[q]), int'(m_cells[q] > 0));
    endtask

    task automatic drain_all();
        for (int q = 0; q < NQ; q++)
            while (m_cells[q] > 0) read_cell(q);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int q = 0; q < NQ; q++) begin m_used[q] = 0; m_cells[q] = 0; end
        rst_n = 1'b0; cfg_mode = 2'd0; cfg_wide = 1'b1; cw = 8;
        cfg_cell_words = 7'd8; cfg_nib = 4'b0;
        in_soc = 1'b0; in_en_n = 1'b1; in_data = '0; in_addr = '0; out_en_n = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_clav == 4'b0, "R1 out_clav", int'(out_clav), 0);
        chk(err_flag == 1'b0, "R1 err_flag", int'(err_flag), 0);
        chk(in_clav == 1'b1, "R1 in_clav", int'(in_clav), 1);

        // R11: reads on empty queues
        out_en_n = 4'h0;
        repeat (3) @(negedge clk);
        out_en_n = 4'hF;
        chk(out_clav == 4'b0, "R11 empty read", int'(out_clav), 0);
        send_cell(0, 1'b1, 5'd1, 18'd0);
        read_cell(1);

        // R10: beat without start-of-cell
        in_en_n = 1'b0; in_soc = 1'b0; in_data = 18'h3;
        @(negedge clk);
        in_en_n = 1'b1;
        @(negedge clk);
        chk(err_flag == 1'b1, "R10 err set", int'(err_flag), 1);
        chk(out_clav == 4'b0, "R10 discarded", int'(out_clav), 0);
        send_cell(1, 1'b0, 5'b01111, 18'd0);
        chk(err_flag == 1'b1, "R10 err sticky", int'(err_flag), 1);
        drain_all();

        // R9: full queue excluded
        cw = 64; cfg_cell_words = 7'd64;
        send_cell(0, 1'b1, 5'd0, 18'd0);
        send_cell(1, 1'b1, 5'b00011, 18'd0);
        send_cell(3, 1'b1, 5'b01111, 18'h00C);
        drain_all();

        // R4: in-band selection, routing word masked by address
        cw = 8; cfg_cell_words = 7'd8; cfg_nib = 4'b1010;
        send_cell(3, 1'b1, 5'b01111, 18'h005);
        send_cell(2, 1'b0, 5'b01011, 18'h002);
        send_cell(2, 1'b1, 5'b00100, 18'h3F6);
        send_cell(0, 1'b0, 5'b10010, 18'd0);
        drain_all();

        for (int r = 0; r < 40; r++) begin
            int nc;
            cw = 8 + int'($urandom % 14);
            cfg_cell_words = 7'(cw);
            cfg_nib = 4'($urandom);
            nc = 1 + int'($urandom % 3);
            for (int c = 0; c < nc; c++)
                send_cell(int'($urandom % 4), 1'($urandom), 5'($urandom % 24), 18'($urandom));
            drain_all();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule